// File: doc/BRIEF.md
# Host Bus Address Latch and Byte-Lane Decoder

This block sits at the edge of a memory-mapped peripheral that has a 32-bit internal register path. It serves an asynchronous host bus. When the host raises its address strobe, the block captures the address, the address-enable and four active-low byte enables. From those captured values it derives three things: whether this device is selected, which internal byte lanes the access touches, and whether the enable pattern is legal for the configured host width.

Data is steered between the host lanes and the internal lanes. A 16-bit host reaches the upper half of the internal word through a word swap selected by address bit 1. An 8-bit host sees its single byte duplicated on both low host lanes. Bytes are never reordered within a half-word. A separate active-low data chip-select bypasses the local address decode and forces a full-width access to the data register. A static width input picks 8-, 16- or 32-bit host operation. The base address register resets to zero and is loaded through a small configuration port.

Top module: `host_bus_front`

## Requirements
- R1: The address, address-enable and byte enables are captured on the clock edge that first sees `host_ads_n` high after it was low. Between captures, and when no base write occurs, `dev_sel`, `lane_mask` and `acc_invalid` do not change when the host address or enable inputs change.
- R2: `dev_sel` is high when the captured address-enable is low and captured address bits [15:4] equal the base register. The base register resets to 0 and takes `cfg_base` on a clock edge with `cfg_we` high.
- R3: While `host_dcs_n` is low, the following hold regardless of the address-enable, the address decode, the byte enables and the width mode:
  - `dreg_sel` is high and `dev_sel` is low;
  - `lane_mask` is 4'hF and `acc_invalid` is low;
  - data is steered as in 32-bit mode.
- R4: In 32-bit mode (`bus_mode` 2'b10 or 2'b11), the captured `be_n[3:0]` (bit k is lane k, low means enabled) maps to `lane_mask` as follows: 0000→F, 1100→3, 0011→C, 1110→1, 1101→2, 1011→4, 0111→8. Every other pattern is invalid.
- R5: In 16-bit mode (`bus_mode` 2'b01), only `be_n[1:0]` is used and captured address bit 1 (a1) selects the internal half. The mapping is: 00→3, or C when a1 is set; 10→1, or 4 when a1 is set; 01→2, or 8 when a1 is set. Pattern 11 is invalid.
- R6: In 8-bit mode (`bus_mode` 2'b00), the single-byte patterns map as in 16-bit mode. Patterns 00 and 11 are invalid.
- R7: An invalid pattern raises `acc_invalid`, produces no `reg_we`, and drives `host_rdata` to zero.
- R8: Write data is steered by width. In 32-bit mode `reg_wdata` equals `host_wdata`. In 16-bit mode `host_wdata[15:0]` is placed in both halves. In 8-bit mode `host_wdata[7:0]` is placed in all four lanes.
- R9: For a valid access that hits (either `dev_sel` or `dreg_sel` is high), read data is steered by width:
  - 32-bit mode returns `reg_rdata` unchanged;
  - 16-bit mode returns the selected half on [15:0], with the upper 16 bits zero;
  - 8-bit mode returns the selected byte on both [7:0] and [15:8], with the upper 16 bits zero.
  Without a valid hit, `host_rdata` is zero.
- R10: `reg_we` equals `lane_mask` when `host_wr` is high, the access hits and the access is valid. Otherwise `reg_we` is zero.
- R11: After reset, the captured address-enable is high and the captured byte enables are all high. As a result, `dev_sel` is low, and `reg_we` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Base register load |
| cfg_base | input | AW-BASE_LSB | New base value |
| host_addr | input | AW-1 | Host address bits [AW-1:1] |
| host_aen | input | 1 | Address-enable, low enables decode |
| host_be_n | input | 4 | Active-low byte enables |
| host_ads_n | input | 1 | Active-low address strobe |
| host_dcs_n | input | 1 | Active-low data chip-select |
| bus_mode | input | 2 | 00 8-bit, 01 16-bit, 1x 32-bit |
| host_wr | input | 1 | Write cycle qualifier |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Steered read data |
| reg_rdata | input | 32 | Internal register read data |
| reg_wdata | output | 32 | Steered write data |
| reg_we | output | 4 | Per-lane write strobes |
| lane_mask | output | 4 | Internal lanes of the access |
| acc_invalid | output | 1 | Illegal enable pattern |
| dev_sel | output | 1 | Local device decode |
| dreg_sel | output | 1 | Data register chip-select active |

## Verification
The bench builds the block with its defaults: a 16-bit address and a 4-bit decode offset, so the base register is 12 bits wide. With these values, every one of the 16 byte-enable patterns can be swept against both values of address bit 1 in all three width modes. Each combination is checked for its lane mask, validity, write strobes, write steering and read steering. Around that sweep, the bench covers the base compare with a match and a mismatch, the address-enable gate, a base reload, an address that changes without a strobe, and the chip-select override applied on top of an illegal pattern.

// File: rtl/host_bus_front.sv
module host_bus_front #(
  parameter int AW       = 16,
  parameter int BASE_LSB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [AW-BASE_LSB-1:0] cfg_base,
  input  logic [AW-1:1]          host_addr,
  input  logic                   host_aen,
  input  logic [3:0]             host_be_n,
  input  logic                   host_ads_n,
  input  logic                   host_dcs_n,
  input  logic [1:0]             bus_mode,
  input  logic                   host_wr,
  input  logic [31:0]            host_wdata,
  output logic [31:0]            host_rdata,
  input  logic [31:0]            reg_rdata,
  output logic [31:0]            reg_wdata,
  output logic [3:0]             reg_we,
  output logic [3:0]             lane_mask,
  output logic                   acc_invalid,
  output logic                   dev_sel,
  output logic                   dreg_sel
);
  localparam int BW = AW - BASE_LSB;
  localparam logic [1:0] MODE8  = 2'b00;
  localparam logic [1:0] MODE16 = 2'b01;

  logic [BW-1:0] base_q, tag_q;
  logic          a1_q, aen_q, ads_q;
  logic [3:0]    be_q;
  logic          strobe_rise, wide, hit;
  logic [7:0]    rd_byte;
  logic          unused_addr;

  assign unused_addr = ^host_addr[BASE_LSB-1:2];
  assign strobe_rise = host_ads_n & ~ads_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      tag_q  <= '0;
      a1_q   <= 1'b0;
      aen_q  <= 1'b1;
      be_q   <= 4'hF;
      ads_q  <= 1'b1;
    end else begin
      ads_q <= host_ads_n;
      if (cfg_we) base_q <= cfg_base;
      if (strobe_rise) begin
        tag_q <= host_addr[AW-1:BASE_LSB];
        a1_q  <= host_addr[1];
        aen_q <= host_aen;
        be_q  <= host_be_n;
      end
    end
  end

  assign dreg_sel = ~host_dcs_n;
  assign dev_sel  = host_dcs_n & ~aen_q & (tag_q == base_q);
  assign wide     = dreg_sel | bus_mode[1];
  assign hit      = dev_sel | dreg_sel;

  always_comb begin
    lane_mask   = 4'h0;
    acc_invalid = 1'b0;
    if (dreg_sel) begin
      lane_mask = 4'hF;
    end else if (bus_mode[1]) begin
      case (be_q)
        4'b0000: lane_mask = 4'hF;
        4'b1100: lane_mask = 4'h3;
        4'b0011: lane_mask = 4'hC;
        4'b1110: lane_mask = 4'h1;
        4'b1101: lane_mask = 4'h2;
        4'b1011: lane_mask = 4'h4;
        4'b0111: lane_mask = 4'h8;
        default: acc_invalid = 1'b1;
      endcase
    end else begin
      case (be_q[1:0])
        2'b00: if (bus_mode == MODE16) lane_mask = a1_q ? 4'hC : 4'h3;
               else acc_invalid = 1'b1;
        2'b10: lane_mask = a1_q ? 4'h4 : 4'h1;
        2'b01: lane_mask = a1_q ? 4'h8 : 4'h2;
        default: acc_invalid = 1'b1;
      endcase
    end
  end

  assign reg_we = (host_wr && hit && !acc_invalid) ? lane_mask : 4'h0;

  always_comb begin
    if (wide)                   reg_wdata = host_wdata;
    else if (bus_mode == MODE8) reg_wdata = {4{host_wdata[7:0]}};
    else                        reg_wdata = {2{host_wdata[15:0]}};
  end

  always_comb begin
    rd_byte = reg_rdata[31:24];
    if (lane_mask[0])      rd_byte = reg_rdata[7:0];
    else if (lane_mask[1]) rd_byte = reg_rdata[15:8];
    else if (lane_mask[2]) rd_byte = reg_rdata[23:16];
    host_rdata = '0;
    if (hit && !acc_invalid) begin
      if (wide)                   host_rdata = reg_rdata;
      else if (bus_mode == MODE8) host_rdata = {16'h0, rd_byte, rd_byte};
      else host_rdata = {16'h0, a1_q ? reg_rdata[31:16] : reg_rdata[15:0]};
    end
  end

  AST_DECODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_rise && !cfg_we && $stable(host_dcs_n)) |=> $stable(dev_sel)); // R1
  AST_AEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    aen_q |-> !dev_sel); // R2
  AST_DCS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !host_dcs_n |-> (lane_mask == 4'hF && !acc_invalid && !dev_sel)); // R3
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_invalid |-> (reg_we == 4'h0 && host_rdata == 32'h0)); // R7
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == MODE8 && host_dcs_n && !acc_invalid) |-> $countones(lane_mask) == 1); // R6
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> host_rdata[31:16] == 16'h0); // R9
endmodule

// File: tb/host_bus_front_bench.sv
`timescale 1ns/1ps
module host_bus_front_bench;
  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [11:0] cfg_base = '0;
  logic [15:1] host_addr = '0;
  logic host_aen = 1, host_ads_n = 1, host_dcs_n = 1, host_wr = 0;
  logic [3:0] host_be_n = 4'hF;
  logic [1:0] bus_mode = 2'b10;
  logic [31:0] host_wdata = 32'h11223344, reg_rdata = 32'hA1B2C3D4;
  logic [31:0] host_rdata, reg_wdata;
  logic [3:0] reg_we, lane_mask;
  logic acc_invalid, dev_sel, dreg_sel;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  host_bus_front u_host_bus_front (.*);

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic strobe(input logic [15:1] a, input logic aen, input logic [3:0] be);
    @(negedge clk);
    host_addr = a; host_aen = aen; host_be_n = be; host_ads_n = 0;
    @(negedge clk);
    host_ads_n = 1;
    @(negedge clk);
  endtask

  task automatic load_base(input logic [11:0] b);
    @(negedge clk); cfg_base = b; cfg_we = 1;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic logic [4:0] model(input int mode, input logic [3:0] be, input logic a1);
    logic [3:0] lo;
    if (mode == 2) begin
      case (be)
        4'b0000: return {1'b0, 4'hF};
        4'b1100: return {1'b0, 4'h3};
        4'b0011: return {1'b0, 4'hC};
        default: for (int k = 0; k < 4; k++) if (be == ~(4'b1 << k)) return {1'b0, 4'b1 << k};
      endcase
      return 5'h10;
    end
    lo = a1 ? 4'h4 : 4'h1;
    if (be[1:0] == 2'b10) return {1'b0, lo};
    if (be[1:0] == 2'b01) return {1'b0, lo << 1};
    if (be[1:0] == 2'b00 && mode == 1) return {1'b0, lo | (lo << 1)};
    return 5'h10;
  endfunction

  initial begin
    #(5.0 * 150000);
    total++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [4:0] m;
    logic [31:0] exp_rd, exp_wd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    eq("R11 dev_sel", dev_sel, 0);
    eq("R11 reg_we", reg_we, 0);
    eq("R11 rdata", host_rdata, 0);
    eq("R11 invalid", acc_invalid, 1);
    strobe({12'h000, 2'b00, 1'b0}, 0, 4'h0);
    eq("R2 base resets to zero", dev_sel, 1);

    load_base(12'h123);
    host_wr = 1;
    for (int mode = 0; mode < 3; mode++) begin
      bus_mode = mode[1:0];
      for (int a1 = 0; a1 < 2; a1++)
        for (int be = 0; be < 16; be++) begin
          strobe({12'h123, 2'b00, a1[0]}, 0, be[3:0]);
          m = model(mode, be[3:0], a1[0]);
          eq(mode == 2 ? "R4 mask" : (mode == 1 ? "R5 mask" : "R6 mask"), lane_mask, {28'h0, m[3:0]});
          eq("R7 invalid flag", acc_invalid, m[4]);
          eq("R10 reg_we", reg_we, m[4] ? 0 : m[3:0]);
          eq("R2 dev_sel", dev_sel, 1);
          exp_rd = 0;
          if (!m[4]) begin
            if (mode == 2) exp_rd = reg_rdata;
            else if (mode == 1) exp_rd = (reg_rdata >> (16 * a1)) & 32'hFFFF;
            else for (int k = 0; k < 4; k++)
              if (m[k]) exp_rd = ((reg_rdata >> (8 * k)) & 32'hFF) * 32'h101;
          end
          eq("R9 R7 rdata", host_rdata, exp_rd);
          exp_wd = (mode == 2) ? host_wdata : (mode == 1 ? (host_wdata & 32'hFFFF) * 32'h10001
                                                        : (host_wdata & 32'hFF) * 32'h01010101);
          eq("R8 wdata", reg_wdata, exp_wd);
        end
    end

    bus_mode = 2'b10;
    strobe({12'h123, 2'b00, 1'b0}, 1, 4'h0);
    eq("R2 aen high blocks", dev_sel, 0);
    eq("R10 no hit no we", reg_we, 0);
    eq("R9 no hit rdata", host_rdata, 0);
    strobe({12'h124, 2'b00, 1'b0}, 0, 4'h0);
    eq("R2 mismatch", dev_sel, 0);
    @(negedge clk); host_addr = {12'h123, 3'b000}; host_be_n = 4'hF;
    @(negedge clk); @(negedge clk);
    eq("R1 no strobe sel", dev_sel, 0);
    eq("R1 no strobe mask", lane_mask, 4'hF);
    load_base(12'h124);
    @(negedge clk);
    eq("R2 base reload", dev_sel, 1);

    bus_mode = 2'b01;
    strobe({12'h000, 2'b00, 1'b1}, 1, 4'hF);
    @(negedge clk); host_dcs_n = 0;
    @(negedge clk);
    eq("R3 dreg_sel", dreg_sel, 1);
    eq("R3 dev_sel low", dev_sel, 0);
    eq("R3 mask", lane_mask, 4'hF);
    eq("R3 valid", acc_invalid, 0);
    eq("R3 reg_we", reg_we, 4'hF);
    eq("R3 wdata", reg_wdata, host_wdata);
    eq("R3 rdata", host_rdata, reg_rdata);
    host_dcs_n = 1;
    @(negedge clk);
    eq("R3 released", dreg_sel, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule